// File: doc/BRIEF.md
# Flash Converter Thermometer-to-Binary Encoder

This block is the digital back end of a flash analog-to-digital converter. It receives the parallel decisions of the comparator bank as a thermometer code and registers them all on one conversion clock. It then turns the code into a binary count in two stages. The first stage forms a Gray code with XOR networks, one network per output bit. The second stage turns that Gray code into plain binary with a prefix XOR that starts at the top bit. A complete conversion leaves the block on every clock cycle.

Comparators can flip on their own, and a lone stray one far above the top of the run is a common error. A static control can enable a filter that clears any thermometer bit that reads 1 while both of its neighbours read 0. Below the lowest tap the filter assumes a 1, and above the highest tap it assumes a 0. The Gray intermediate keeps the damage from a fault that gets through the filter small. Each set bit flips only one Gray bit, so a stray bit can never switch on the large number of outputs that a one-hot decoder would.

The output resolution is the parameter `CODE_W`, and the number of taps is 2^CODE_W − 1. The default is 4 bits from 15 taps. In this document, tap T_k is `therm_in[k-1]`.

Top module: `therm_gray_encoder`

## Requirements
- R1: During and right after a synchronous active-high reset, `code_out` is 0 and `code_valid` is 0.
- R2: A clean thermometer input has bits T1..Tc set and all others clear, for any c from 0 to 15. Such an input produces `code_out` = c, so all zeros gives 0 and all ones gives 15.
- R3: An input presented while `sample_en` is high appears on `code_out` after exactly two rising clock edges, with `code_valid` high for that one cycle. Samples on consecutive cycles give results on consecutive cycles.
- R4: A cycle with `sample_en` low captures nothing. Two edges later `code_valid` is low and `code_out` keeps its previous value.
- R5: When `filt_en` is 1, a tap that reads 1 while both of its neighbours read 0 is cleared before encoding. A clean run with one isolated stray bit above it therefore encodes as the run length alone.
- R6: Filter boundaries: the filter treats the position below T1 as 1, so T1 alone is kept and gives 1. It treats the position above T15 as 0, so T15 alone is cleared and gives 0.
- R7: When `filt_en` is 0, the taps reach the encoder unchanged. The encoder forms the Gray bits as follows:
  - G3 = T8
  - G2 = T4^T12
  - G1 = T2^T6^T10^T14
  - G0 = the XOR of all odd taps

  Binary bit i is then the XOR of G3 down to Gi. For example, T8 alone gives 15, T15 alone gives 1, and T1 with T3 gives 0.
- R8: Enabling the filter never changes the result for a clean thermometer code.
- R9: A reset asserted while samples are in flight discards them. After the reset edge, outputs read 0 and `code_valid` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| filt_en | input | 1 | Static control: 1 enables the isolated-bubble filter |
| sample_en | input | 1 | Capture enable for the current comparator word |
| therm_in | input | 2^CODE_W−1 | Comparator decisions; bit k−1 is tap T_k |
| code_out | output | CODE_W | Registered binary conversion result |
| code_valid | output | 1 | High for one cycle per captured sample |

## Verification
The bench builds the block with the default `CODE_W` of 4, which gives 15 taps. At that size every one of the 16 clean codes is small enough to draw many times in random runs, in both filter modes. Every legal position of a single stray bit above a run can also be drawn with the filter enabled. The size also allows exact boundary cases for the filter (T1 alone, T15 alone) and hand-derived Gray results for faulty words that pass the filter while it is disabled. Random gaps in `sample_en`, together with a reset in the middle of traffic, exercise the two-stage pipeline timing and the hold behaviour.

// File: rtl/tge_pkg.sv
package tge_pkg;

    // Largest supported resolution; bounds the width of computed tap masks.
    localparam int unsigned MAX_W    = 8;
    localparam int unsigned MAX_TAPS = (1 << MAX_W) - 1;

    typedef enum logic {
        FILT_BYPASS = 1'b0,
        FILT_ACTIVE = 1'b1
    } filt_mode_e;

    // Taps (1-based index k) that feed Gray bit j: k is an odd multiple of 2^j.
    function automatic logic [MAX_TAPS-1:0] gray_tap_mask(input int unsigned j);
        logic [MAX_TAPS-1:0] m;
        m = '0;
        for (int unsigned k = 1; k <= MAX_TAPS; k++) begin
            if (((k >> j) & 1) == 1 && (k % (1 << j)) == 0)
                m[k-1] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/tge_capture.sv
module tge_capture #(
    parameter int unsigned TAPS = 15
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sample_en,
    input  logic [TAPS-1:0] therm_in,
    output logic [TAPS-1:0] cap_bits,
    output logic            cap_valid
);

    // Every comparator bit is registered on the same edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_bits  <= '0;
            cap_valid <= 1'b0;
        end else begin
            cap_valid <= sample_en;
            if (sample_en)
                cap_bits <= therm_in;
        end
    end

    // R3: a valid capture holds exactly the word presented one edge earlier.
    p_capture_r3: assert property (@(posedge clk) disable iff (rst)
        cap_valid |-> cap_bits == $past(therm_in));

endmodule

// File: rtl/tge_bubble.sv
module tge_bubble #(
    parameter int unsigned TAPS = 15
) (
    input  tge_pkg::filt_mode_e mode,
    input  logic [TAPS-1:0]     bits_in,
    output logic [TAPS-1:0]     bits_out
);

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        logic lo_n;
        logic hi_n;
        // Below the lowest tap counts as 1, above the highest as 0.
        if (k == 0) begin : g_lo_edge
            assign lo_n = 1'b1;
        end else begin : g_lo_mid
            assign lo_n = bits_in[k-1];
        end
        if (k == TAPS - 1) begin : g_hi_edge
            assign hi_n = 1'b0;
        end else begin : g_hi_mid
            assign hi_n = bits_in[k+1];
        end
        assign bits_out[k] = (mode == tge_pkg::FILT_ACTIVE)
                           ? (bits_in[k] & (lo_n | hi_n))
                           : bits_in[k];
    end

endmodule

// File: rtl/tge_gray.sv
module tge_gray #(
    parameter int unsigned CODE_W = 4,
    parameter int unsigned TAPS   = (1 << CODE_W) - 1
) (
    input  logic [TAPS-1:0]   bits,
    output logic [CODE_W-1:0] gray
);

    // One XOR network per Gray bit over the taps at odd multiples of 2^j.
    for (genvar j = 0; j < CODE_W; j++) begin : g_bit
        localparam logic [tge_pkg::MAX_TAPS-1:0] MASK_FULL = tge_pkg::gray_tap_mask(j);
        localparam logic [TAPS-1:0]              MASK      = MASK_FULL[TAPS-1:0];
        assign gray[j] = ^(bits & MASK);
    end

endmodule

// File: rtl/therm_gray_encoder.sv
module therm_gray_encoder #(
    parameter  int unsigned CODE_W = 4,
    localparam int unsigned TAPS   = (1 << CODE_W) - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              filt_en,
    input  logic              sample_en,
    input  logic [TAPS-1:0]   therm_in,
    output logic [CODE_W-1:0] code_out,
    output logic              code_valid
);

    logic [TAPS-1:0]     cap_bits;
    logic                cap_valid;
    logic [TAPS-1:0]     filt_bits;
    logic [CODE_W-1:0]   gray;
    logic [CODE_W-1:0]   bin;
    tge_pkg::filt_mode_e mode;

    assign mode = tge_pkg::filt_mode_e'(filt_en);

    tge_capture #(.TAPS(TAPS)) cap_i (
        .clk       (clk),
        .rst       (rst),
        .sample_en (sample_en),
        .therm_in  (therm_in),
        .cap_bits  (cap_bits),
        .cap_valid (cap_valid)
    );

    tge_bubble #(.TAPS(TAPS)) bub_i (
        .mode     (mode),
        .bits_in  (cap_bits),
        .bits_out (filt_bits)
    );

    tge_gray #(.CODE_W(CODE_W), .TAPS(TAPS)) gray_i (
        .bits (filt_bits),
        .gray (gray)
    );

    // Gray to binary: each binary bit is the XOR of all Gray bits at or above it.
    for (genvar i = 0; i < CODE_W; i++) begin : g_bin
        assign bin[i] = ^gray[CODE_W-1:i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_out   <= '0;
            code_valid <= 1'b0;
        end else begin
            code_valid <= cap_valid;
            if (cap_valid)
                code_out <= bin;
        end
    end

    // R4: a valid result can only come from a sample enabled two edges earlier.
    p_valid_src_r4: assert property (@(posedge clk) disable iff (rst)
        code_valid |-> $past(sample_en, 2));

    // R4: without a new result the output word is held.
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!code_valid && !$past(rst)) |-> $stable(code_out));

    // R8: the filter leaves a clean run of ones untouched.
    p_clean_pass_r8: assert property (@(posedge clk) disable iff (rst)
        ((cap_bits & (cap_bits + 1'b1)) == '0) |-> filt_bits == cap_bits);

    // R2: a clean filtered word encodes as its count of ones.
    p_count_r2: assert property (@(posedge clk) disable iff (rst)
        (code_valid && $past(((filt_bits & (filt_bits + 1'b1)) == '0)))
        |-> code_out == CODE_W'($past($countones(filt_bits))));

endmodule

// File: tb/therm_gray_encoder_tb_top.sv
module therm_gray_encoder_tb_top;

    localparam int unsigned W    = 4;
    localparam int unsigned TAPS = (1 << W) - 1;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            filt_en = 1'b0;
    logic            sample_en = 1'b0;
    logic [TAPS-1:0] therm_in = '0;
    logic [W-1:0]    code_out;
    logic            code_valid;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // History of the two most recent drives: index 1 is due now.
    bit        h_en  [2];
    logic [W-1:0] h_exp [2];
    string     h_tag [2];
    logic [W-1:0] exp_code = '0;

    therm_gray_encoder #(.CODE_W(W)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .filt_en    (filt_en),
        .sample_en  (sample_en),
        .therm_in   (therm_in),
        .code_out   (code_out),
        .code_valid (code_valid)
    );

    always #5 clk = ~clk;

    function automatic logic [TAPS-1:0] run_of(input int unsigned c);
        return TAPS'((32'd1 << c) - 1);
    endfunction

    task automatic check(input string tag, input logic [W-1:0] e_code, input bit e_val);
        n_cmp++;
        if (code_out !== e_code || code_valid !== e_val) begin
            n_bad++;
            $display("FAIL %s: code=%0d valid=%0b expected code=%0d valid=%0b",
                     tag, code_out, code_valid, e_code, e_val);
        end
    endtask

    task automatic clear_hist();
        for (int i = 0; i < 2; i++) begin
            h_en[i] = 1'b0; h_exp[i] = '0; h_tag[i] = "R4 idle";
        end
        exp_code = '0;
    endtask

    // One cycle: check the entry driven two negedges ago, then drive a new one.
    task automatic step(input bit e, input logic [TAPS-1:0] t,
                        input logic [W-1:0] expv, input string tag);
        @(negedge clk);
        if (h_en[1]) exp_code = h_exp[1];
        check(h_tag[1], exp_code, h_en[1]);
        h_en[1] = h_en[0]; h_exp[1] = h_exp[0]; h_tag[1] = h_tag[0];
        h_en[0] = e;       h_exp[0] = expv;     h_tag[0] = tag;
        sample_en = e;
        therm_in  = t;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, '0, "R4 idle");
    endtask

    task automatic set_filt(input bit f);
        idle(2);
        filt_en = f;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        clear_hist();
        repeat (3) @(negedge clk);
        check("R1 during reset", '0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", '0, 1'b0);

        // R2 directed boundaries and back-to-back R3 throughput.
        set_filt(1'b0);
        step(1'b1, '0, 4'd0, "R2 all zeros");
        step(1'b1, '1, 4'd15, "R2 all ones");
        step(1'b1, run_of(8), 4'd8, "R3 back-to-back");
        step(1'b0, '1, 4'd0, "R4 ignored word");
        idle(1);

        // R7 filter disabled: faulty words follow the Gray mapping.
        step(1'b1, TAPS'(1) << 7, 4'd15, "R7 T8 alone");
        step(1'b1, TAPS'(1) << 14, 4'd1, "R7 T15 alone");
        step(1'b1, TAPS'(5), 4'd0, "R7 T1 and T3");

        // R5/R6 filter enabled.
        set_filt(1'b1);
        step(1'b1, TAPS'(1) << 7, 4'd0, "R5 T8 alone cleared");
        step(1'b1, TAPS'(1) << 14, 4'd0, "R6 T15 alone cleared");
        step(1'b1, TAPS'(1), 4'd1, "R6 T1 alone kept");
        step(1'b1, TAPS'(5), 4'd1, "R5 T3 stray over T1");
        step(1'b1, '1, 4'd15, "R8 all ones filtered");

        // Random clean codes in both modes with random enable gaps.
        for (int pass = 0; pass < 2; pass++) begin
            set_filt(pass[0]);
            for (int i = 0; i < 300; i++) begin
                int unsigned c;
                bit e;
                c = $urandom_range(0, TAPS);
                e = ($urandom_range(0, 9) != 0);
                step(e, run_of(c), W'(c), pass == 0 ? "R2 random clean" : "R8 random clean");
            end
        end

        // Random single stray bit above a run, filter enabled.
        set_filt(1'b1);
        for (int i = 0; i < 300; i++) begin
            int unsigned c;
            int unsigned p;
            c = $urandom_range(0, TAPS - 2);
            p = $urandom_range(c + 2, TAPS);
            step(1'b1, run_of(c) | (TAPS'(1) << (p - 1)), W'(c), "R5 random stray");
        end

        // R9: reset with samples in flight.
        step(1'b1, '1, 4'd15, "R9 before reset");
        @(negedge clk);
        rst = 1'b1;
        sample_en = 1'b0;
        @(negedge clk);
        check("R9 reset mid-flight", '0, 1'b0);
        rst = 1'b0;
        clear_hist();
        @(negedge clk);
        check("R9 after release", '0, 1'b0);
        step(1'b1, run_of(3), 4'd3, "R9 recovery");
        idle(2);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule